// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a bank of already-synchronized input pins and raises one combined interrupt line. Each pin has an enable bit, a pending bit and a detection mode. In the base mode a pin flags any change of level. When the pin's extended mode is on, two more per-pin choices apply. One picks edge or level. The other picks the active sense: rising/high or falling/low.

Software uses a small register bus. The enable bits and all the configuration bits change only through paired set and clear addresses: a one written at a bit position sets or clears that bit, and a zero leaves it alone. A read of the pending register returns the pending bits and clears them in the same access. An event present in that same cycle sets its bit again, so the event is not lost. A level-mode pin whose level is still active therefore stays pending after the read.

Top module: `intr_pin_detector`

## Requirements
- R1: After reset, the enable mask, pending bits, extended-mode, level-select and polarity bits all read 0, and `irq` is 0.
- R2: A write to address 0 sets, and a write to address 1 clears, each enable bit whose `bus_wdata` bit is 1. Other bits are unchanged. Address 2 reads the enable mask back.
- R3: A pin whose extended-mode bit is 0 sets its pending bit on both rising and falling level changes. The bit is visible in the cycle after the clock edge that samples the new level.
- R4: With extended mode on (address 4 sets, 5 clears, 10 reads) and edge selected (address 6 selects edge, 7 selects level, 11 reads, 1 = level), the pin detects only rising edges if polarity is high, or only falling edges if polarity is low. Address 8 selects high, 9 selects low, 12 reads, 1 = high.
- R5: In level mode the pending bit is set in every cycle the pin is at its active level (high for polarity 1, low for polarity 0). It stays set across a status read while that level lasts.
- R6: Turning extended mode off returns the pin to any-change detection and keeps its level and polarity settings.
- R7: A read of address 3 returns the pending bits and clears them at the same clock edge.
- R8: An event that is detected in the same cycle as a read of address 3 leaves its pending bit set after the read.
- R9: Pending bits are set whatever the mask holds. `irq` is 1 exactly when some pin is both pending and enabled.
- R10: After all ones are written to address 1, `irq` is 0 even if bits are pending.
- R11: The pin levels seen in the first cycle after reset release produce no event. They only become the starting reference.
- R12: Reads of addresses other than 2, 3, 10, 11 and 12 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NPIN | Synchronized pin levels |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (read side effects only when high) |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | NPIN | Write data, one bit per pin |
| bus_rdata | output | NPIN | Read data for the addressed register |
| irq | output | 1 | Combined interrupt |

## Verification
The bench aims at the status read that coincides with a fresh edge. A design that clears after it sets would drop that event for good. It also checks that level-mode pins are still pending after a read, since a design that treats level like edge would report a still-active level only once. It drives pins high before reset release, which would create a false first event in a design that compares against a zeroed history. It also checks that a masked pin still records its event, so a design that gates the pending bit with the mask would lose it when the mask opens later.

// File: rtl/intr_det_pkg.sv
package intr_det_pkg;

  typedef enum logic [3:0] {
    A_IRQ_ON   = 4'd0,
    A_IRQ_OFF  = 4'd1,
    A_IRQ_MASK = 4'd2,
    A_PEND     = 4'd3,
    A_XM_ON    = 4'd4,
    A_XM_OFF   = 4'd5,
    A_EDGE     = 4'd6,
    A_LEVEL    = 4'd7,
    A_HI       = 4'd8,
    A_LO       = 4'd9,
    A_XM_RD    = 4'd10,
    A_LVL_RD   = 4'd11,
    A_HI_RD    = 4'd12
  } reg_addr_e;

  // Event rule for one pin: base mode = any change, extended = edge/level x sense
  function automatic logic pin_event(input logic xm, input logic lvl, input logic hi,
                                     input logic cur, input logic prev);
    logic r;
    if (!xm)      r = cur ^ prev;
    else if (lvl) r = hi ? cur : ~cur;
    else          r = hi ? (cur & ~prev) : (~cur & prev);
    return r;
  endfunction

  // Set-dominant pending update: a clear from a status read loses to a new event
  function automatic logic pend_next(input logic pend, input logic clr, input logic evt);
    return (pend & ~clr) | evt;
  endfunction

endpackage

// File: rtl/intr_setclr_reg.sv
module intr_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_v) & ~clr_v;
  end
endmodule

// File: rtl/intr_cfg_regs.sv
module intr_cfg_regs
  import intr_det_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] mask_q,
  output logic [NPIN-1:0] xm_q,
  output logic [NPIN-1:0] lvl_q,
  output logic [NPIN-1:0] hi_q
);
  localparam int NREG = 4;

  // index: 0 mask, 1 extended mode, 2 level select, 3 high polarity
  logic [NREG-1:0][3:0] set_addr, clr_addr;
  logic [NREG-1:0][NPIN-1:0] q_all;

  assign set_addr = {A_HI,  A_LEVEL, A_XM_ON,  A_IRQ_ON};
  assign clr_addr = {A_LO,  A_EDGE,  A_XM_OFF, A_IRQ_OFF};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [NPIN-1:0] s_v, c_v;
    assign s_v = (bus_we && bus_addr == AW'(set_addr[g])) ? bus_wdata : '0;
    assign c_v = (bus_we && bus_addr == AW'(clr_addr[g])) ? bus_wdata : '0;
    intr_setclr_reg #(.W(NPIN)) u_reg (
      .clk(clk), .rst_n(rst_n), .set_v(s_v), .clr_v(c_v), .q(q_all[g])
    );
  end

  assign mask_q = q_all[0];
  assign xm_q   = q_all[1];
  assign lvl_q  = q_all[2];
  assign hi_q   = q_all[3];
endmodule

// File: rtl/intr_detect.sv
module intr_detect
  import intr_det_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_lvl,
  input  logic [NPIN-1:0] xm_q,
  input  logic [NPIN-1:0] lvl_q,
  input  logic [NPIN-1:0] hi_q,
  output logic [NPIN-1:0] evt,
  output logic            armed
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      armed  <= 1'b0;
    end else begin
      prev_q <= pin_lvl;
      armed  <= 1'b1;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign evt[i] = armed & pin_event(xm_q[i], lvl_q[i], hi_q[i], pin_lvl[i], prev_q[i]);
  end
endmodule

// File: rtl/intr_pending.sv
module intr_pending
  import intr_det_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] evt,
  input  logic            rd_clr,
  input  logic [NPIN-1:0] mask_q,
  output logic [NPIN-1:0] pend_q,
  output logic            irq
);
  logic [NPIN-1:0] pend_d;

  for (genvar i = 0; i < NPIN; i++) begin : g_pend
    assign pend_d[i] = pend_next(pend_q[i], rd_clr, evt[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq = |(pend_q & mask_q);
endmodule

// File: rtl/intr_pin_detector.sv
module intr_pin_detector
  import intr_det_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_lvl,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  output logic            irq
);
  logic [NPIN-1:0] mask_q, xm_q, lvl_q, hi_q, evt, pend_q;
  logic armed, rd_clr;

  assign rd_clr = bus_re && (bus_addr == AW'(A_PEND));

  intr_cfg_regs #(.NPIN(NPIN), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mask_q(mask_q), .xm_q(xm_q), .lvl_q(lvl_q), .hi_q(hi_q)
  );

  intr_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .xm_q(xm_q), .lvl_q(lvl_q),
    .hi_q(hi_q), .evt(evt), .armed(armed)
  );

  intr_pending #(.NPIN(NPIN)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd_clr(rd_clr), .mask_q(mask_q),
    .pend_q(pend_q), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_IRQ_MASK)) bus_rdata = mask_q;
    if (bus_addr == AW'(A_PEND))     bus_rdata = pend_q;
    if (bus_addr == AW'(A_XM_RD))    bus_rdata = xm_q;
    if (bus_addr == AW'(A_LVL_RD))   bus_rdata = lvl_q;
    if (bus_addr == AW'(A_HI_RD))    bus_rdata = hi_q;
  end
endmodule

// File: rtl/intr_pin_detector_chk.sv
module intr_pin_detector_chk
  import intr_det_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] pin_lvl,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] xm_q,
  input logic [NPIN-1:0] lvl_q,
  input logic [NPIN-1:0] hi_q,
  input logic [NPIN-1:0] evt,
  input logic [NPIN-1:0] pend_q,
  input logic            armed,
  input logic            rd_clr,
  input logic            irq
);
  logic [NPIN-1:0] lvl_hi_act, rise_only_low;
  assign lvl_hi_act    = xm_q & lvl_q & hi_q & pin_lvl;
  assign rise_only_low = xm_q & ~lvl_q & hi_q & ~pin_lvl;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pend_q == '0 && mask_q == '0 && !irq));

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(A_IRQ_ON)) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_event_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

  assert_rise_ignores_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & rise_only_low) == '0);

  assert_level_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((evt & lvl_hi_act) == lvl_hi_act));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == '0) |=> (pend_q == '0));

  assert_mask_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_first_cycle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (evt == '0));
endmodule

bind intr_pin_detector intr_pin_detector_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mask_q(mask_q), .xm_q(xm_q), .lvl_q(lvl_q), .hi_q(hi_q),
  .evt(evt), .pend_q(pend_q), .armed(armed), .rd_clr(rd_clr), .irq(irq)
);

// File: tb/tb_intr_pin_detector.sv
module tb_intr_pin_detector;
  localparam int N  = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]  pins = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0] m_mask, m_xm, m_lvl, m_hi, m_pend, m_prev;
  bit m_armed;

  intr_pin_detector #(.NPIN(N), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .bus_we(we), .bus_re(re),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  // Expected events, written as a case over the per-pin mode bits
  function automatic logic [N-1:0] exp_evt(input logic [N-1:0] cur);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      case ({m_xm[i], m_lvl[i], m_hi[i]})
        3'b000, 3'b001, 3'b010, 3'b011: e[i] = (cur[i] != m_prev[i]);
        3'b101: e[i] = cur[i] && !m_prev[i];
        3'b100: e[i] = !cur[i] && m_prev[i];
        3'b111: e[i] = cur[i];
        default: e[i] = !cur[i];
      endcase
    end
    return m_armed ? e : '0;
  endfunction

  function automatic logic [N-1:0] exp_read(input logic [AW-1:0] a);
    case (a)
      4'd2:  return m_mask;
      4'd3:  return m_pend;
      4'd10: return m_xm;
      4'd11: return m_lvl;
      4'd12: return m_hi;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] p, input logic w, input logic r,
                     input logic [AW-1:0] a, input logic [N-1:0] d, input string req);
    logic [N-1:0] ev, np;
    @(negedge clk);
    pins = p; we = w; re = r; addr = a; wdata = d;
    #1;
    if (r) check(req, "read", rdata, exp_read(a));
    ev = exp_evt(p);
    np = (r && a == 4'd3) ? '0 : m_pend;
    np = np | ev;
    if (w) begin
      case (a)
        4'd0: m_mask = m_mask | d;
        4'd1: m_mask = m_mask & ~d;
        4'd4: m_xm   = m_xm | d;
        4'd5: m_xm   = m_xm & ~d;
        4'd6: m_lvl  = m_lvl & ~d;
        4'd7: m_lvl  = m_lvl | d;
        4'd8: m_hi   = m_hi | d;
        4'd9: m_hi   = m_hi & ~d;
        default: ;
      endcase
    end
    m_pend = np; m_prev = p; m_armed = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; re = 1'b0;
    check(req, "irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_pend & m_mask)});
  endtask

  task automatic idle(input logic [N-1:0] p, input string req);
    cyc(p, 1'b0, 1'b0, '0, '0, req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    cyc(pins, 1'b0, 1'b1, a, '0, req);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d, input string req);
    cyc(pins, 1'b1, 1'b0, a, d, req);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] p;
    void'($urandom(32'h5eed_1234));
    m_mask = '0; m_xm = '0; m_lvl = '0; m_hi = '0; m_pend = '0; m_prev = '0; m_armed = 1'b0;
    pins = 32'h0000_0101;            // high before release: R11
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state, R11 no spurious event from initial levels
    idle(pins, "R11");
    rd(4'd3, "R11");
    rd(4'd2, "R1"); rd(4'd10, "R1"); rd(4'd11, "R1"); rd(4'd12, "R1");
    check("R1", "irq", {{(N-1){1'b0}}, irq}, '0);
    rd(4'd13, "R12"); rd(4'd7, "R12");
    // R3 any change in base mode, R9 pending with mask closed
    idle(32'h0000_0103, "R3");
    idle(32'h0000_0102, "R3");
    rd(4'd3, "R3");
    rd(4'd3, "R7");
    // R2 mask set/clear
    wr(4'd0, 32'h0000_00F3, "R2"); rd(4'd2, "R2");
    wr(4'd1, 32'h0000_0030, "R2"); rd(4'd2, "R2");
    idle(32'h0000_0100, "R9");        // pin1 falls, enabled -> irq
    rd(4'd3, "R9");
    idle(32'h0000_0000, "R9");        // pin8 change, masked -> pending, no irq
    rd(4'd3, "R9");
    // R4 extended rising edge on pin 4, falling on pin 6
    wr(4'd4, 32'h0000_0050, "R4"); wr(4'd6, 32'h0000_0050, "R4");
    wr(4'd8, 32'h0000_0010, "R4");
    rd(4'd10, "R4"); rd(4'd11, "R4"); rd(4'd12, "R4");
    idle(32'h0000_0050, "R4"); rd(4'd3, "R4");
    idle(32'h0000_0000, "R4"); rd(4'd3, "R4");
    // R5 level high on pin 5, level low on pin 7
    wr(4'd4, 32'h0000_00A0, "R5"); wr(4'd7, 32'h0000_00A0, "R5");
    wr(4'd8, 32'h0000_0020, "R5");
    idle(32'h0000_0020, "R5");
    rd(4'd3, "R5"); rd(4'd3, "R5");
    idle(32'h0000_0080, "R5");
    rd(4'd3, "R5"); rd(4'd3, "R5");
    // R6 extended off: pin 4 back to any change, settings kept
    wr(4'd5, 32'h0000_00F0, "R6");
    rd(4'd11, "R6"); rd(4'd12, "R6");
    idle(32'h0000_0000, "R6"); rd(4'd3, "R6");
    idle(32'h0000_0010, "R6"); idle(32'h0000_0000, "R6"); rd(4'd3, "R6");
    // R8 edge in the same cycle as a status read
    cyc(32'h0000_0004, 1'b0, 1'b1, 4'd3, '0, "R8");
    rd(4'd3, "R8"); rd(4'd3, "R8");
    // R10 all ones to disable
    wr(4'd0, '1, "R10");
    idle(32'hFFFF_0000, "R10");
    wr(4'd1, '1, "R10");
    idle(32'hFFFF_0000, "R10");
    rd(4'd2, "R10");
    rd(4'd3, "R10");
    // random traffic against the model
    p = pins;
    for (int k = 0; k < 3000; k++) begin
      int unsigned op;
      logic [AW-1:0] a;
      if ($urandom_range(0, 3) == 0) p = p ^ (32'h1 << $urandom_range(0, N-1));
      op = $urandom_range(0, 9);
      a  = AW'($urandom_range(0, 13));
      if (op < 3)      cyc(p, 1'b1, 1'b0, a, $urandom & $urandom, "R9");
      else if (op < 6) cyc(p, 1'b0, 1'b1, (op == 3) ? a : 4'd3, '0, "R7");
      else             idle(p, "R3");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule